// File: doc/BRIEF.md
# Write Leveling Exit Sequencer

This block sits on the memory-controller side of a DDR3 interface and takes one rank out of write leveling and back to normal operation. While the leveling engine runs, the sequencer keeps the controller's DQS output enable and the rank's ODT pin asserted. An exit request, raised after the last leveling sample, starts a fixed series of steps. First it holds DQS for a programmable capture window and samples the final DQ feedback bit at the end of that window. Next it releases DQS and ODT together and waits out the ODT input setup time and the termination turn-off time. It then issues one mode-register-set command to MR1 that clears the leveling-enable bit. Finally it counts down the two mode-register delays.

Every wait is a cycle count taken from a register input, and each count must be at least 1. The counts must stay stable while the block is busy, and the MRS-to-MRS delay must not exceed the MRS-to-any-command delay. Commands appear on a plain DDR3 command port made of chip select, row strobe, column strobe, write enable, bank address and address. The flag `mrs_ok` tells the controller when a further mode-register command may be issued. The flag `ready` tells it when any command may be issued, or when the next rank may be leveled.

Top module: `wl_exit_seq`

## Requirements
- R1: After reset the block is idle: busy=0, ready=0, mrs_ok=0, fb_valid=0, dqs_oe=1, odt=1, and the command port shows NOP ({cs_n,ras_n,cas_n,we_n}=4'b0111).
- R2: An exit request taken while not busy makes busy high from the next cycle on, and keeps dqs_oe and odt high for exactly t_wlo_cap cycles.
- R3: The DQ feedback bit is sampled in the last cycle of the capture window. fb_valid is then high for exactly one cycle, the first cycle after the window, and fb_value carries the sampled bit in that cycle.
- R4: dqs_oe and odt fall in the same cycle, and odt is never high while dqs_oe is low.
- R5: Exactly t_is + t_odt_off cycles after the window ends, one MRS command is issued with {cs_n,ras_n,cas_n,we_n}=4'b0000, ba=3'b001 (MR1) and addr equal to mr1_word with bit LVL_BIT (default 7) forced to 0. At that point odt and dqs_oe are both low.
- R6: In every cycle without a command the port shows NOP (4'b0111), with ba and addr at zero.
- R7: mrs_ok rises t_mrd cycles after the MRS cycle and stays high until the next sequence starts.
- R8: t_mod cycles after the MRS cycle, ready rises and busy falls in the same cycle. odt and dqs_oe stay low until another exit request arrives.
- R9: An exit request raised while busy is ignored, and the timing of the sequence in progress does not change.
- R10: An exit request taken in the ready state starts a new sequence for the next rank. ready and mrs_ok drop, and dqs_oe and odt are driven high again for its capture window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exit_req | input | 1 | Request to leave write leveling |
| dq_fb | input | 1 | DQ feedback bit from the rank |
| mr1_word | input | MR_W | MR1 payload; the leveling-enable bit is ignored |
| t_wlo_cap | input | CNT_W | Output delay plus capture margin, in cycles |
| t_is | input | CNT_W | ODT input setup, in cycles |
| t_odt_off | input | CNT_W | ODT off latency plus termination turn-off, in cycles |
| t_mrd | input | CNT_W | MRS-to-MRS delay, in cycles |
| t_mod | input | CNT_W | MRS-to-any-command delay, in cycles |
| dqs_oe | output | 1 | Controller DQS drive enable |
| odt | output | 1 | ODT pin to the rank |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 3 | Bank address (mode register select) |
| addr | output | MR_W | Address / mode register payload |
| busy | output | 1 | Sequence in progress |
| fb_valid | output | 1 | One-cycle strobe for the captured feedback |
| fb_value | output | 1 | Captured final DQ feedback |
| mrs_ok | output | 1 | Further mode-register commands allowed |
| ready | output | 1 | Rank accepts normal commands |

## Verification
The assertions check the ordering rules on every cycle. ODT is never high without DQS drive, and an MRS only ever appears with both ODT and DQS low and the leveling bit clear. Only legal commands are ever driven, the feedback strobe lasts a single cycle, and ready implies both mrs_ok and low ODT. The exact cycle counts of each wait can only be shown by the bench scenarios. These include the boundary where every count is 1, the sampling of feedback in the last window cycle only, a request ignored mid-sequence, and a restart from the ready state.

// File: rtl/wl_exit_seq.sv
module wl_exit_seq #(
  parameter int CNT_W   = 8,
  parameter int MR_W    = 16,
  parameter int LVL_BIT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             exit_req,
  input  logic             dq_fb,
  input  logic [MR_W-1:0]  mr1_word,
  input  logic [CNT_W-1:0] t_wlo_cap,
  input  logic [CNT_W-1:0] t_is,
  input  logic [CNT_W-1:0] t_odt_off,
  input  logic [CNT_W-1:0] t_mrd,
  input  logic [CNT_W-1:0] t_mod,
  output logic             dqs_oe,
  output logic             odt,
  output logic             cs_n,
  output logic             ras_n,
  output logic             cas_n,
  output logic             we_n,
  output logic [2:0]       ba,
  output logic [MR_W-1:0]  addr,
  output logic             busy,
  output logic             fb_valid,
  output logic             fb_value,
  output logic             mrs_ok,
  output logic             ready
);

  localparam int EW = CNT_W + 1;
  localparam logic [2:0] MR1_SEL = 3'b001;

  typedef enum logic [2:0] {
    S_IDLE, S_HOLD, S_SETUP, S_TOFF, S_MRS, S_WAIT, S_DONE
  } st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic             take;
  logic             is_mrs;
  logic [MR_W-1:0]  mr1_clean;

  assign take      = exit_req && !busy;
  assign is_mrs    = (st == S_MRS);
  assign busy      = !(st == S_IDLE || st == S_DONE);
  assign dqs_oe    = (st == S_IDLE || st == S_HOLD);
  assign odt       = dqs_oe;
  assign ready     = (st == S_DONE);
  assign mrs_ok    = ready || (st == S_WAIT && cnt >= t_mrd);

  always_comb begin
    mr1_clean          = mr1_word;
    mr1_clean[LVL_BIT] = 1'b0;
  end

  assign cs_n  = 1'b0;
  assign ras_n = !is_mrs;
  assign cas_n = !is_mrs;
  assign we_n  = !is_mrs;
  assign ba    = is_mrs ? MR1_SEL : 3'b000;
  assign addr  = is_mrs ? mr1_clean : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      fb_valid <= 1'b0;
      fb_value <= 1'b0;
    end else begin
      fb_valid <= 1'b0;
      if (take) begin
        st  <= S_HOLD;
        cnt <= t_wlo_cap - 1'b1;
      end else begin
        case (st)
          S_HOLD:
            if (cnt == '0) begin
              fb_value <= dq_fb;
              fb_valid <= 1'b1;
              st       <= S_SETUP;
              cnt      <= t_is - 1'b1;
            end else cnt <= cnt - 1'b1;
          S_SETUP:
            if (cnt == '0) begin
              st  <= S_TOFF;
              cnt <= t_odt_off - 1'b1;
            end else cnt <= cnt - 1'b1;
          S_TOFF:
            if (cnt == '0) st <= S_MRS;
            else cnt <= cnt - 1'b1;
          S_MRS: begin
            cnt <= {{(CNT_W-1){1'b0}}, 1'b1};
            st  <= (t_mod <= 1) ? S_DONE : S_WAIT;
          end
          S_WAIT:
            if (EW'(cnt) + EW'(1) >= EW'(t_mod)) st <= S_DONE;
            else cnt <= cnt + 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_ODT_NEEDS_DQS: assert property (@(posedge clk) disable iff (!rst_n)
    odt |-> dqs_oe); // R4
  AST_MRS_TERM_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> (!odt && !dqs_oe)); // R5
  AST_MRS_LVL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!ras_n && !cas_n && !we_n) |-> (!addr[LVL_BIT] && ba == MR1_SEL)); // R5
  AST_CMD_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    ({cs_n, ras_n, cas_n, we_n} == 4'b0111) || ({cs_n, ras_n, cas_n, we_n} == 4'b0000)); // R6
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |=> !fb_valid); // R3
  AST_STROBE_AFTER_DQS: assert property (@(posedge clk) disable iff (!rst_n)
    fb_valid |-> !dqs_oe); // R3
  AST_READY_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> (mrs_ok && !odt && !busy)); // R8
  AST_BUSY_IGNORES_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ready && !dqs_oe && exit_req) |=> !dqs_oe); // R9

endmodule

// File: tb/sim_wl_exit_seq.sv
module sim_wl_exit_seq;
  localparam int CNT_W = 8;
  localparam int MR_W  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic exit_req = 1'b0;
  logic dq_fb = 1'b0;
  logic [MR_W-1:0]  mr1_word = '0;
  logic [CNT_W-1:0] t_wlo_cap = 8'd1, t_is = 8'd1, t_odt_off = 8'd1, t_mrd = 8'd1, t_mod = 8'd1;
  logic dqs_oe, odt, cs_n, ras_n, cas_n, we_n, busy, fb_valid, fb_value, mrs_ok, ready;
  logic [2:0] ba;
  logic [MR_W-1:0] addr;

  always #2 clk = ~clk;

  wl_exit_seq #(.CNT_W(CNT_W), .MR_W(MR_W), .LVL_BIT(7)) u0 (
    .clk(clk), .rst_n(rst_n), .exit_req(exit_req), .dq_fb(dq_fb), .mr1_word(mr1_word),
    .t_wlo_cap(t_wlo_cap), .t_is(t_is), .t_odt_off(t_odt_off), .t_mrd(t_mrd), .t_mod(t_mod),
    .dqs_oe(dqs_oe), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .busy(busy), .fb_valid(fb_valid), .fb_value(fb_value),
    .mrs_ok(mrs_ok), .ready(ready));

  typedef struct packed {
    logic drv; logic busy; logic mrs; logic fbv; logic fbval; logic mok; logic rdy;
  } exp_t;

  exp_t q[$];
  logic [MR_W-1:0] exp_addr;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        chk(dqs_oe == e.drv, "R2/R4 dqs_oe", dqs_oe, e.drv);
        chk(odt == e.drv, "R2/R4 odt", odt, e.drv);
        chk(busy == e.busy, "R8 busy", busy, e.busy);
        chk(fb_valid == e.fbv, "R3 fb_valid", fb_valid, e.fbv);
        if (e.fbv) chk(fb_value == e.fbval, "R3 fb_value", fb_value, e.fbval);
        chk(mrs_ok == e.mok, "R7 mrs_ok", mrs_ok, e.mok);
        chk(ready == e.rdy, "R8 ready", ready, e.rdy);
        if (e.mrs) begin
          chk({cs_n, ras_n, cas_n, we_n} == 4'b0000, "R5 cmd", {cs_n, ras_n, cas_n, we_n}, 0);
          chk(ba == 3'b001, "R5 ba", ba, 1);
          chk(addr == exp_addr, "R5 addr", addr, exp_addr);
        end else begin
          chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R6 nop", {cs_n, ras_n, cas_n, we_n}, 7);
          chk(ba == 3'b000 && addr == '0, "R6 idle fields", {ba, addr}, 0);
        end
      end
    end
  end

  task automatic run_exit(input int tw, input int ti, input int to, input int tmrd, input int tmod,
                          input logic val, input logic [MR_W-1:0] mr, input bit poke);
    int m;
    int len;
    exp_t e;
    t_wlo_cap = tw[CNT_W-1:0]; t_is = ti[CNT_W-1:0]; t_odt_off = to[CNT_W-1:0];
    t_mrd = tmrd[CNT_W-1:0]; t_mod = tmod[CNT_W-1:0]; mr1_word = mr;
    exp_addr = mr & ~(16'h1 << 7);
    m = tw + ti + to + 1;
    len = m + tmod;
    @(negedge clk);
    exit_req = 1'b1;
    dq_fb = ~val;
    @(posedge clk);
    #1;
    for (int k = 1; k <= len; k++) begin
      e.drv   = (k <= tw);
      e.busy  = (k < len);
      e.mrs   = (k == m);
      e.fbv   = (k == tw + 1);
      e.fbval = val;
      e.mok   = (k > m) && (k - m >= tmrd);
      e.rdy   = (k == len);
      q.push_back(e);
    end
    for (int k = 1; k <= len; k++) begin
      @(negedge clk);
      exit_req = poke && (k == 2 || k == tw + 1 || k == m); // R9: ignored while busy
      dq_fb = (k == tw) ? val : ~val;
    end
    exit_req = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : driver
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !ready && !mrs_ok && !fb_valid, "R1 flags", {busy, ready, mrs_ok, fb_valid}, 0);
    chk(dqs_oe && odt, "R1 drive", {dqs_oe, odt}, 3);
    chk({cs_n, ras_n, cas_n, we_n} == 4'b0111, "R1 nop", {cs_n, ras_n, cas_n, we_n}, 7);
    run_exit(3, 1, 2, 4, 12, 1'b1, 16'h0084, 0);
    // R10 restart from ready state
    run_exit(1, 1, 1, 1, 1, 1'b0, 16'hFFFF, 0);
    run_exit(5, 2, 3, 2, 6, 1'b1, 16'h1A80, 1);
    run_exit(2, 3, 1, 3, 3, 1'b0, 16'h0246, 1);
    repeat (4) @(negedge clk);
    chk(ready && mrs_ok && !odt && !dqs_oe, "R8 hold", {ready, mrs_ok, odt, dqs_oe}, 12);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule